// File: doc/BRIEF.md
# Block-Cipher Job Register Front-End

This block is the register front-end of a 128-bit block-cipher engine that reads and writes its data in memory. A host programs a job through a 32-bit write port: a source address, a destination address, a byte count, a 128-bit key, a 128-bit initial chaining value and a command word. Setting the launch bit in the command word starts the job. The block holds every job parameter steady for the whole job. It sends a single-cycle launch pulse, with the mode flags, to the cipher and memory-mover datapath. When the datapath reports completion, the block sets a sticky completion flag.

The datapath is outside this block. It is represented by a completion strobe and a 128-bit next-chaining-value input. After a chained (CBC) job, that value is captured into the chaining-value registers, so software can read them back and continue the chain with the next job. The engine key is a separate hidden copy. It is reloaded from the key registers only when the launch command asks for it. Completion flags are cleared by writing 1 to them. Two of the three stored mask bits gate the interrupt output. Both bus ports are plain: a write is accepted in any cycle that `wr_en` is high, and reads are combinational. No valid/ready back-pressure exists, because the register file can always take a write.

Top module: `cx_crypt_regs`

## Requirements
- R1: After reset, every readable register reads 0, and `job_busy`, `job_start` and `irq` are 0.
- R2: Parameters sit at byte offsets 0x10 (source), 0x14 (destination) and 0x18 (length). The key words sit at 0x30, 0x34, 0x38 and 0x3C, and the chaining-value words at 0x40, 0x44, 0x48 and 0x4C. Word 0, at the lowest address, forms bits 31:0 of the 128-bit value. All of these read back what was written and drive the matching `job_*` outputs.
- R3: The command word is at 0x00. A write with bit 0 set, while idle and with a non-zero length, raises `job_start` for exactly the one cycle after the write. At that point the mode outputs are: bit 1 = encrypt, bit 2 = load key, bit 3 = destination coherency, bit 4 = source coherency, bit 5 = CBC. A read of 0x00 returns bits 5:1 as last launched, with bit 0 always 0.
- R4: A launch command written while the length register holds 0 produces no pulse, leaves `job_busy` at 0, and leaves the command readback unchanged.
- R5: `job_busy` is 1 from the launch until the cycle after `job_done`. While it is 1, writes to the parameter, key and chaining-value registers are ignored, and so are writes to the command word.
- R6: If a launch has load-key set, `job_key` takes the value of the key registers, starting with the launch-pulse cycle. Otherwise `job_key` keeps its previous value, whatever the key registers hold.
- R7: `job_done` while busy sets the channel-A completion flag, which is bit 16 of the status word at 0x08. `chb_done` sets the channel-B completion flag, bit 17. Both flags stay set until cleared.
- R8: A status write clears each completion flag whose bit (16 or 17) is written as 1, leaves flags written as 0 unchanged, and stores bits 2:0 as the mask. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is 1 exactly when (flag A and mask bit 0) or (flag B and mask bit 1) is true.
- R10: When a CBC job completes, the chaining-value registers take `next_iv`. When an ECB job completes, they keep their value.
- R11: Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| job_start | output | 1 | One-cycle launch pulse |
| job_busy | output | 1 | Job in progress |
| job_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| job_load_key | output | 1 | Key was reloaded for this job |
| job_dst_coh | output | 1 | Destination coherency request |
| job_src_coh | output | 1 | Source coherency request |
| job_cbc | output | 1 | 1 = CBC, 0 = ECB |
| job_src | output | 32 | Source address |
| job_dst | output | 32 | Destination address |
| job_len | output | 32 | Byte count |
| job_key | output | 128 | Engine (hidden) key |
| job_iv | output | 128 | Chaining value |
| job_done | input | 1 | Datapath completion strobe, channel A |
| chb_done | input | 1 | Completion strobe, channel B |
| next_iv | input | 128 | Final chaining value from the datapath |
| irq | output | 1 | Masked completion interrupt |

## Verification
Some rules are checked by the in-RTL assertions on every cycle:
- the launch pulse lasts one cycle and only ever starts a busy period;
- parameters stay frozen while busy;
- the hidden key does not move on a launch without load-key;
- a completion flag is set on completion and cleared by a write-one.

Other behaviour can only be shown by the bench's scenarios: the mapping of each offset and bit, chaining-value capture only for CBC jobs, the rejected zero-length launch, the set-over-clear race and the mask gating of `irq`. The bench covers these with random jobs checked against a bench model, plus directed cases.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_SRC  = 8'h10;
  localparam logic [7:0] OFS_DST  = 8'h14;
  localparam logic [7:0] OFS_LEN  = 8'h18;
  localparam logic [7:0] OFS_KEY  = 8'h30;
  localparam logic [7:0] OFS_IV   = 8'h40;

  typedef struct packed {
    logic cbc;
    logic src_coh;
    logic dst_coh;
    logic load_key;
    logic encrypt;
  } job_mode_t;
endpackage

// File: rtl/cx_param_bank.sv
module cx_param_bank #(
  parameter int DW = 32,
  parameter int NW = 4,
  localparam int BW = DW * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          lock,
  input  logic          iv_cap,
  input  logic [BW-1:0] next_iv,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] dst_q,
  output logic [DW-1:0] len_q,
  output logic [BW-1:0] key_q,
  output logic [BW-1:0] iv_q
);
  import cx_pkg::*;
  logic we;
  assign we = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
    end else if (we) begin
      if (wr_addr == OFS_SRC) src_q <= wr_data;
      if (wr_addr == OFS_DST) dst_q <= wr_data;
      if (wr_addr == OFS_LEN) len_q <= wr_data;
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    localparam logic [7:0] KA = OFS_KEY + 8'(4 * i);
    localparam logic [7:0] IA = OFS_IV + 8'(4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_q[i*DW +: DW] <= '0;
        iv_q[i*DW +: DW]  <= '0;
      end else begin
        if (we && wr_addr == KA) key_q[i*DW +: DW] <= wr_data;
        if (iv_cap) iv_q[i*DW +: DW] <= next_iv[i*DW +: DW];
        else if (we && wr_addr == IA) iv_q[i*DW +: DW] <= wr_data;
      end
    end
  end

  // R5: parameters frozen while a job runs
  a_r5_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(src_q));
  a_r5_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(len_q));
endmodule

// File: rtl/cx_job_ctrl.sv
module cx_job_ctrl #(
  parameter int BW = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [5:0]       cmd_wdata,
  input  logic             len_nz,
  input  logic [BW-1:0]    key_regs,
  input  logic             job_done,
  output logic             start,
  output logic             busy,
  output cx_pkg::job_mode_t mode,
  output logic [BW-1:0]    hidden_key,
  output logic             done_evt,
  output logic             iv_cap
);
  import cx_pkg::*;
  logic launch;
  assign launch   = cmd_we && cmd_wdata[0] && !busy && len_nz;
  assign done_evt = busy && job_done;
  assign iv_cap   = done_evt && mode.cbc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start      <= 1'b0;
      busy       <= 1'b0;
      mode       <= '0;
      hidden_key <= '0;
    end else begin
      start <= launch;
      if (launch) begin
        busy <= 1'b1;
        mode <= job_mode_t'(cmd_wdata[5:1]);
        if (cmd_wdata[2]) hidden_key <= key_regs;
      end else if (done_evt) begin
        busy <= 1'b0;
      end
    end
  end

  // R3: launch pulse lasts one cycle and opens a busy period
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  a_r5_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  a_r5_busy_only_by_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start);
  // R6: hidden key untouched without load-key
  a_r6_key_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mode.load_key) |-> $stable(hidden_key));
endmodule

// File: rtl/cx_status.sv
module cx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_we,
  input  logic [1:0] clr_bits,
  input  logic [2:0] mask_wr,
  input  logic       set_a,
  input  logic       set_b,
  output logic [1:0] pend,
  output logic [2:0] mask,
  output logic       irq
);
  logic [1:0] set_v;
  assign set_v = {set_b, set_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (set_v[i]) pend[i] <= 1'b1;
        else if (st_we && clr_bits[i]) pend[i] <= 1'b0;
      end
      if (st_we) mask <= mask_wr;
    end
  end

  assign irq = |(pend & mask[1:0]);

  // R7 / R8: set has priority, write-one clears
  a_r7_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    set_a |=> pend[0]);
  a_r8_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && clr_bits[0] && !set_a) |=> !pend[0]);
  a_r8_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && !(st_we && clr_bits[1])) |=> pend[1]);
endmodule

// File: rtl/cx_crypt_regs.sv
module cx_crypt_regs #(
  parameter int DW = 32,
  parameter int NW = 4,
  localparam int BW = DW * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [7:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          job_start,
  output logic          job_busy,
  output logic          job_encrypt,
  output logic          job_load_key,
  output logic          job_dst_coh,
  output logic          job_src_coh,
  output logic          job_cbc,
  output logic [DW-1:0] job_src,
  output logic [DW-1:0] job_dst,
  output logic [DW-1:0] job_len,
  output logic [BW-1:0] job_key,
  output logic [BW-1:0] job_iv,
  input  logic          job_done,
  input  logic          chb_done,
  input  logic [BW-1:0] next_iv,
  output logic          irq
);
  import cx_pkg::*;
  job_mode_t  mode;
  logic [BW-1:0] key_regs;
  logic done_evt, iv_cap;
  logic [1:0] pend;
  logic [2:0] mask;

  cx_param_bank #(.DW(DW), .NW(NW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock(job_busy), .iv_cap(iv_cap), .next_iv(next_iv),
    .src_q(job_src), .dst_q(job_dst), .len_q(job_len),
    .key_q(key_regs), .iv_q(job_iv)
  );

  cx_job_ctrl #(.BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(wr_en && wr_addr == OFS_CMD), .cmd_wdata(wr_data[5:0]),
    .len_nz(|job_len), .key_regs(key_regs), .job_done(job_done),
    .start(job_start), .busy(job_busy), .mode(mode), .hidden_key(job_key),
    .done_evt(done_evt), .iv_cap(iv_cap)
  );

  cx_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .st_we(wr_en && wr_addr == OFS_STAT), .clr_bits(wr_data[17:16]),
    .mask_wr(wr_data[2:0]), .set_a(done_evt), .set_b(chb_done),
    .pend(pend), .mask(mask), .irq(irq)
  );

  assign job_encrypt  = mode.encrypt;
  assign job_load_key = mode.load_key;
  assign job_dst_coh  = mode.dst_coh;
  assign job_src_coh  = mode.src_coh;
  assign job_cbc      = mode.cbc;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CMD:  rd_data = DW'({mode, 1'b0});
      OFS_STAT: rd_data = DW'({pend, 13'b0, mask});
      OFS_SRC:  rd_data = job_src;
      OFS_DST:  rd_data = job_dst;
      OFS_LEN:  rd_data = job_len;
      default:  rd_data = '0;
    endcase
    for (int i = 0; i < NW; i++) begin
      if (rd_addr == OFS_KEY + 8'(4 * i)) rd_data = key_regs[i*DW +: DW];
      if (rd_addr == OFS_IV + 8'(4 * i))  rd_data = job_iv[i*DW +: DW];
    end
  end

  // R10: chaining value moves only on a CBC completion
  a_r10_iv_only_cbc: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !mode.cbc) |=> $stable(job_iv));
endmodule

// File: tb/cx_crypt_regs_bench.sv
`timescale 1ns/1ps
module cx_crypt_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic wr_en = 0, job_done = 0, chb_done = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [127:0] next_iv = 0, job_key, job_iv;
  logic [31:0] job_src, job_dst, job_len;
  logic job_start, job_busy, job_encrypt, job_load_key, job_dst_coh;
  logic job_src_coh, job_cbc, irq;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  cx_crypt_regs u_cx_crypt_regs (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic rd128(input logic [7:0] base, output logic [127:0] v);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin rd(base + 8'(4*i), w); v[i*32 +: 32] = w; end
  endtask

  task automatic wr128(input logic [7:0] base, input logic [127:0] v);
    for (int i = 0; i < 4; i++) wr(base + 8'(4*i), v[i*32 +: 32]);
  endtask

  task automatic finish_job(input logic [127:0] nv);
    @(negedge clk); job_done = 1; next_iv = nv;
    @(negedge clk); job_done = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, s, d, l;
    logic [127:0] hk, k, v, nv, r;
    logic [4:0] f;
    void'($urandom(32'h1234_5678));
    hk = '0;
    #10; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, w); check("R1 cmd", w, 0);
    rd(8'h08, w); check("R1 status", w, 0);
    rd(8'h10, w); check("R1 src", w, 0);
    rd128(8'h40, r); check("R1 iv", r, 0);
    check("R1 outs", {job_busy, job_start, irq}, 0);
    // R11 unmapped
    wr(8'h20, 32'hdead_beef); rd(8'h20, w); check("R11 unmapped", w, 0);
    rd(8'h0c, w); check("R11 unmapped 0c", w, 0);
    // R4 zero length launch
    wr(8'h00, 32'h3f); check("R4 no pulse", job_start, 0);
    check("R4 not busy", job_busy, 0);
    rd(8'h00, w); check("R4 cmd unchanged", w, 0);

    // random jobs
    for (int j = 0; j < 40; j++) begin
      s = $urandom; d = $urandom; l = {20'd0, 8'($urandom_range(1, 255)), 4'd0};
      k = rnd128(); v = rnd128(); nv = rnd128(); f = 5'($urandom_range(0, 31));
      wr(8'h10, s); wr(8'h14, d); wr(8'h18, l);
      wr128(8'h30, k); wr128(8'h40, v);
      rd(8'h18, w); check("R2 len readback", w, l);
      rd128(8'h30, r); check("R2 key readback", r, k);
      wr(8'h00, {26'd0, f, 1'b1});
      if (f[1]) hk = k;
      check("R3 pulse", job_start, 1);
      check("R3 mode", {job_cbc, job_src_coh, job_dst_coh, job_load_key, job_encrypt}, f);
      check("R6 engine key", job_key, hk);
      check("R2 outputs", {job_src, job_dst, job_len}, {s, d, l});
      check("R2 iv out", job_iv, v);
      @(negedge clk); check("R3 pulse width", job_start, 0);
      check("R5 busy", job_busy, 1);
      wr(8'h10, ~s); rd(8'h10, w); check("R5 src locked", w, s);
      wr(8'h40, ~v[31:0]); rd(8'h40, w); check("R5 iv locked", w, v[31:0]);
      wr(8'h00, 32'h3f); check("R5 relaunch ignored", job_start, 0);
      rd(8'h00, w); check("R3 cmd readback", w, {26'd0, f, 1'b0});
      finish_job(nv);
      check("R5 idle after done", job_busy, 0);
      rd(8'h08, w); check("R7 pend A", w, 32'h0001_0000);
      rd128(8'h40, r); check("R10 iv after job", r, f[4] ? nv : v);
      wr(8'h08, 32'h0001_0000); rd(8'h08, w); check("R8 clear", w, 0);
    end

    // R6 directed: key registers change, no load-key
    wr128(8'h30, rnd128()); wr(8'h00, 32'h01);
    check("R6 key kept", job_key, hk);
    finish_job(0);
    // R9 interrupt masking
    wr(8'h08, 32'h0001_0001); check("R9 no pend", irq, 0);
    wr(8'h00, 32'h01); finish_job(0);
    check("R9 irq A", irq, 1);
    wr(8'h08, 32'h0000_0002); check("R9 masked", irq, 0);
    rd(8'h08, w); check("R8 write 0 keeps", w, 32'h0001_0002);
    @(negedge clk); chb_done = 1; @(negedge clk); chb_done = 0;
    check("R9 irq B", irq, 1);
    rd(8'h08, w); check("R7 pend B", w, 32'h0003_0002);
    wr(8'h08, 32'h0002_0004); rd(8'h08, w); check("R8 clear B only", w, 32'h0001_0004);
    check("R9 irq off", irq, 0);
    // R8 set beats clear
    wr(8'h08, 32'h0001_0000);
    wr(8'h00, 32'h01);
    @(negedge clk); job_done = 1; wr_en = 1; wr_addr = 8'h08; wr_data = 32'h0001_0000;
    @(negedge clk); job_done = 0; wr_en = 0;
    rd(8'h08, w); check("R8 set wins", w, 32'h0001_0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule